// File: doc/BRIEF.md
# Bin Mask and Select Register Loader

This block holds two 64-bit binning control values, a bin mask and a bin select, and updates them from a stream of 32-bit command words. A packet begins with a header word that names an operation and gives the number of payload words that follow. Full-width operations load an entire register from two payload words. Half-width operations replace one 32-bit half and leave the other half as it was. Both registers drive output pins, so downstream binning logic can read them at any time.

The word input is a valid/ready handshake. A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The block deasserts `in_ready` for exactly one cycle after the last payload word of a well-formed write, while the write commits. At all other times it accepts a word every cycle, including during discarded packets. The sender must hold `in_word` stable while `in_valid` is high and `in_ready` is low.

Packets with a payload length that does not fit their operation, and packets with unknown opcodes, are consumed in full so that the next header is found in the right place. A length error sets a sticky flag.

Top module: `bin_ctl_loader`

## Requirements
- R1: After a synchronous reset, both registers read zero, `pkt_err` is low and `in_ready` is high.
- R2: The header word carries the opcode in bits 7:0 and the payload count in bits 15:8. Bits 31:16 of a header are ignored.
- R3: Opcode 0x50 with count 2 loads the bin mask. The first payload word goes to bits 63:32 and the second goes to bits 31:0.
- R4: Opcode 0x51 with count 2 loads the bin select in the same word order as R3.
- R5: Opcodes 0x60 (mask) and 0x62 (select) with count 1 replace bits 31:0 of their register with the payload word and keep bits 63:32.
- R6: Opcodes 0x61 (mask) and 0x63 (select) with count 1 replace bits 63:32 with the payload word and keep bits 31:0.
- R7: A known opcode whose count differs from its required length (2 for full-width, 1 for half-width), including count 0, sets `pkt_err`. All of its payload words are consumed and neither register changes.
- R8: `pkt_err` stays high until reset, and later well-formed packets still update the registers.
- R9: For an unknown opcode, the given number of payload words is discarded, nothing changes, no error is raised, and the following header is decoded normally.
- R10: A write appears on the outputs at the second rising edge after the edge that accepted the last payload word. `in_ready` is low only in the single cycle between those two edges.
- R11: A packet changes only the register its opcode names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 32 | Command word (header or payload) |
| bin_mask | output | 64 | Current bin mask |
| bin_select | output | 64 | Current bin select |
| pkt_err | output | 1 | Sticky flag for a length error |

## Verification
A miscounted payload counter would make the block read a payload word as a header. This shows up on the next packet: the wrong register is updated or an error is raised where none is due. The bench therefore follows every discarded or malformed packet with a well-formed one and checks the result. A swapped word order or the wrong half being kept shows on the register output one cycle after the commit stall. A commit stall that is missing or one cycle too long shows as a wrong count of `in_ready` low cycles for that packet.

// File: rtl/bmsk_pkg.sv
package bmsk_pkg;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_DATA,
    ST_DROP,
    ST_COMMIT
  } seq_state_e;

  typedef enum logic [1:0] {
    WK_FULL,
    WK_LO,
    WK_HI
  } wr_kind_e;

  typedef struct packed {
    logic     known;
    logic     tgt_sel;   // 0: mask register, 1: select register
    wr_kind_e kind;
  } op_info_t;

endpackage

// File: rtl/bmsk_hdr_decode.sv
module bmsk_hdr_decode
  import bmsk_pkg::*;
#(
  parameter int OPW = 8,
  parameter int CW  = 8,
  parameter logic [OPW-1:0] OP_MASK_FULL = 8'h50,
  parameter logic [OPW-1:0] OP_SEL_FULL  = 8'h51,
  parameter logic [OPW-1:0] OP_MASK_LO   = 8'h60,
  parameter logic [OPW-1:0] OP_MASK_HI   = 8'h61,
  parameter logic [OPW-1:0] OP_SEL_LO    = 8'h62,
  parameter logic [OPW-1:0] OP_SEL_HI    = 8'h63
) (
  input  logic [OPW+CW-1:0] hdr_bits,
  output op_info_t          info,
  output logic [CW-1:0]     count,
  output logic              count_ok
);

  localparam logic [CW-1:0] FULL_LEN = CW'(2);
  localparam logic [CW-1:0] HALF_LEN = CW'(1);

  logic [OPW-1:0] opcode;

  assign opcode = hdr_bits[OPW-1:0];
  assign count  = hdr_bits[OPW +: CW];

  always_comb begin
    info = '{known: 1'b0, tgt_sel: 1'b0, kind: WK_FULL};
    if (opcode == OP_MASK_FULL)     info = '{known: 1'b1, tgt_sel: 1'b0, kind: WK_FULL};
    else if (opcode == OP_SEL_FULL) info = '{known: 1'b1, tgt_sel: 1'b1, kind: WK_FULL};
    else if (opcode == OP_MASK_LO)  info = '{known: 1'b1, tgt_sel: 1'b0, kind: WK_LO};
    else if (opcode == OP_MASK_HI)  info = '{known: 1'b1, tgt_sel: 1'b0, kind: WK_HI};
    else if (opcode == OP_SEL_LO)   info = '{known: 1'b1, tgt_sel: 1'b1, kind: WK_LO};
    else if (opcode == OP_SEL_HI)   info = '{known: 1'b1, tgt_sel: 1'b1, kind: WK_HI};
  end

  assign count_ok = info.known &&
                    (count == ((info.kind == WK_FULL) ? FULL_LEN : HALF_LEN));

endmodule

// File: rtl/bmsk_seq.sv
module bmsk_seq
  import bmsk_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_word,
  input  op_info_t      info,
  input  logic [CW-1:0] count,
  input  logic          count_ok,
  output logic          wr_en,
  output logic          wr_sel,
  output wr_kind_e      wr_kind,
  output logic [DW-1:0] stage_a,
  output logic [DW-1:0] stage_b,
  output logic          err_set
);

  localparam logic [CW-1:0] LAST = CW'(1);

  seq_state_e    state;
  logic [CW-1:0] rem;
  logic          idx;
  logic          accept;

  assign in_ready = (state != ST_COMMIT);
  assign accept   = in_valid && in_ready;
  assign wr_en    = (state == ST_COMMIT);
  assign err_set  = (state == ST_HDR) && accept && info.known && !count_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HDR;
      rem     <= '0;
      idx     <= 1'b0;
      wr_sel  <= 1'b0;
      wr_kind <= WK_FULL;
      stage_a <= '0;
      stage_b <= '0;
    end else begin
      case (state)
        ST_HDR: begin
          if (accept) begin
            rem <= count;
            idx <= 1'b0;
            if (count_ok) begin
              state   <= ST_DATA;
              wr_sel  <= info.tgt_sel;
              wr_kind <= info.kind;
            end else if (count != '0) begin
              state <= ST_DROP;
            end
          end
        end
        ST_DATA: begin
          if (accept) begin
            if (!idx) stage_a <= in_word;
            else      stage_b <= in_word;
            idx <= 1'b1;
            rem <= rem - 1'b1;
            if (rem == LAST) state <= ST_COMMIT;
          end
        end
        ST_DROP: begin
          if (accept) begin
            rem <= rem - 1'b1;
            if (rem == LAST) state <= ST_HDR;
          end
        end
        default: state <= ST_HDR;
      endcase
    end
  end

endmodule

// File: rtl/bmsk_regs.sv
module bmsk_regs
  import bmsk_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 2,
  localparam int RW  = 2 * DW,
  localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  wr_kind_e      wr_kind,
  input  logic [DW-1:0] stage_a,
  input  logic [DW-1:0] stage_b,
  input  logic          err_set,
  output logic [RW-1:0] regs [NREG],
  output logic          err_flag
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && (wr_sel == SW'(g))) begin
        case (wr_kind)
          WK_LO:   regs[g][DW-1:0]  <= stage_a;
          WK_HI:   regs[g][RW-1:DW] <= stage_a;
          default: regs[g]          <= {stage_a, stage_b};
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
  end

endmodule

// File: rtl/bin_ctl_loader.sv
module bin_ctl_loader
  import bmsk_pkg::*;
#(
  parameter int DW  = 32,
  parameter int OPW = 8,
  parameter int CW  = 8,
  localparam int RW = 2 * DW,
  localparam int HW = OPW + CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_word,
  output logic [RW-1:0] bin_mask,
  output logic [RW-1:0] bin_select,
  output logic          pkt_err
);

  op_info_t      info;
  logic [CW-1:0] count;
  logic          count_ok;
  logic          wr_en;
  logic          wr_sel;
  wr_kind_e      wr_kind;
  logic [DW-1:0] stage_a;
  logic [DW-1:0] stage_b;
  logic          err_set;
  logic [RW-1:0] regs [2];

  bmsk_hdr_decode #(.OPW(OPW), .CW(CW)) u_dec (
    .hdr_bits (in_word[HW-1:0]),
    .info     (info),
    .count    (count),
    .count_ok (count_ok)
  );

  bmsk_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_word  (in_word),
    .info     (info),
    .count    (count),
    .count_ok (count_ok),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_kind  (wr_kind),
    .stage_a  (stage_a),
    .stage_b  (stage_b),
    .err_set  (err_set)
  );

  bmsk_regs #(.DW(DW), .NREG(2)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_kind  (wr_kind),
    .stage_a  (stage_a),
    .stage_b  (stage_b),
    .err_set  (err_set),
    .regs     (regs),
    .err_flag (pkt_err)
  );

  assign bin_mask   = regs[0];
  assign bin_select = regs[1];

endmodule

// File: rtl/bmsk_chk.sv
module bmsk_chk #(
  parameter int RW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic [RW-1:0] bin_mask,
  input logic [RW-1:0] bin_select,
  input logic          pkt_err
);

  // R1
  always @(posedge clk) begin
    if (!rst && $past(rst)) begin
      reset_clear_chk: assert (bin_mask == '0 && bin_select == '0 && !pkt_err && in_ready);
    end
  end

  // R10
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> ($stable(bin_mask) && $stable(bin_select)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_err |=> pkt_err);

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bin_mask) |-> $stable(bin_select));

endmodule

bind bin_ctl_loader bmsk_chk #(.RW(RW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .bin_mask   (bin_mask),
  .bin_select (bin_select),
  .pkt_err    (pkt_err)
);

// File: tb/test_bin_ctl_loader.sv
module test_bin_ctl_loader;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [63:0] bin_mask;
  logic [63:0] bin_select;
  logic        pkt_err;

  int n_chk  = 0;
  int n_fail = 0;
  int stall_cnt = 0;

  always #4 clk = ~clk;

  bin_ctl_loader i_bin_ctl_loader (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .bin_mask   (bin_mask),
    .bin_select (bin_select),
    .pkt_err    (pkt_err)
  );

  always @(negedge clk) if (!rst && !in_ready) stall_cnt++;

  typedef struct packed {
    logic [31:0] hdr;
    logic [31:0] p0;
    logic [31:0] p1;
    logic [31:0] p2;
    logic [7:0]  nw;
    logic [63:0] mask;
    logic [63:0] sel;
    logic        err;
    logic [7:0]  stalls;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R3 full mask load, high word first
    '{32'h0000_0250, 32'h1111_2222, 32'h3333_4444, 32'h0, 8'd2, 64'h1111_2222_3333_4444, 64'h0, 1'b0, 8'd1, 8'd3},
    // R4 full select load
    '{32'h0000_0251, 32'hAAAA_0001, 32'h5555_0002, 32'h0, 8'd2, 64'h1111_2222_3333_4444, 64'hAAAA_0001_5555_0002, 1'b0, 8'd1, 8'd4},
    // R5 mask low half
    '{32'h0000_0160, 32'hDEAD_BEEF, 32'h0, 32'h0, 8'd1, 64'h1111_2222_DEAD_BEEF, 64'hAAAA_0001_5555_0002, 1'b0, 8'd1, 8'd5},
    // R6 mask high half
    '{32'h0000_0161, 32'hCAFE_F00D, 32'h0, 32'h0, 8'd1, 64'hCAFE_F00D_DEAD_BEEF, 64'hAAAA_0001_5555_0002, 1'b0, 8'd1, 8'd6},
    // R5 select low half
    '{32'h0000_0162, 32'h0000_00FF, 32'h0, 32'h0, 8'd1, 64'hCAFE_F00D_DEAD_BEEF, 64'hAAAA_0001_0000_00FF, 1'b0, 8'd1, 8'd5},
    // R6 select high half
    '{32'h0000_0163, 32'h1234_5678, 32'h0, 32'h0, 8'd1, 64'hCAFE_F00D_DEAD_BEEF, 64'h1234_5678_0000_00FF, 1'b0, 8'd1, 8'd6},
    // R9 unknown opcode, payload looks like headers
    '{32'h0000_0277, 32'h0000_0250, 32'h0000_0160, 32'h0, 8'd2, 64'hCAFE_F00D_DEAD_BEEF, 64'h1234_5678_0000_00FF, 1'b0, 8'd0, 8'd9},
    // R2 upper header bits ignored
    '{32'hFFFF_0250, 32'h0102_0304, 32'h0506_0708, 32'h0, 8'd2, 64'h0102_0304_0506_0708, 64'h1234_5678_0000_00FF, 1'b0, 8'd1, 8'd2},
    // R7 full packet with count 1
    '{32'h0000_0150, 32'hFFFF_FFFF, 32'h0, 32'h0, 8'd1, 64'h0102_0304_0506_0708, 64'h1234_5678_0000_00FF, 1'b1, 8'd0, 8'd7},
    // R8 writes continue after an error
    '{32'h0000_0251, 32'h0000_0000, 32'h0000_0001, 32'h0, 8'd2, 64'h0102_0304_0506_0708, 64'h0000_0000_0000_0001, 1'b1, 8'd1, 8'd8},
    // R7 half packet with count 3
    '{32'h0000_0360, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 8'd3, 64'h0102_0304_0506_0708, 64'h0000_0000_0000_0001, 1'b1, 8'd0, 8'd7},
    // R11 mask write leaves select alone
    '{32'h0000_0161, 32'h0BAD_F00D, 32'h0, 32'h0, 8'd1, 64'h0BAD_F00D_0506_0708, 64'h0000_0000_0000_0001, 1'b1, 8'd1, 8'd11}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    check("R1 mask", bin_mask, 64'h0);
    check("R1 select", bin_select, 64'h0);
    check("R1 err", {63'h0, pkt_err}, 64'h0);
    check("R1 ready", {63'h0, in_ready}, 64'h1);

    for (int r = 0; r < NV; r++) begin
      stall_cnt = 0;
      send_word(VEC[r].hdr);
      for (int k = 0; k < int'(VEC[r].nw); k++)
        send_word(k == 0 ? VEC[r].p0 : (k == 1 ? VEC[r].p1 : VEC[r].p2));
      go_idle(3);
      check($sformatf("R%0d row %0d mask", VEC[r].req, r), bin_mask, VEC[r].mask);
      check($sformatf("R%0d row %0d select", VEC[r].req, r), bin_select, VEC[r].sel);
      check($sformatf("R%0d row %0d err", VEC[r].req, r), {63'h0, pkt_err}, {63'h0, VEC[r].err});
      // R10 stall cycles per packet
      check($sformatf("R10 row %0d stalls", r), 64'(stall_cnt), 64'(VEC[r].stalls));
    end

    // R1 reset clears state and sticky error
    do_reset();
    check("R1 mask after rerun", bin_mask, 64'h0);
    check("R1 err after rerun", {63'h0, pkt_err}, 64'h0);

    // R9 unknown opcode with count 0 consumes only its header
    send_word(32'h0000_0099);

    // R10 commit timing, driven cycle by cycle
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = 32'h0000_0250;
    @(negedge clk);
    in_word  = 32'hA5A5_A5A5;
    @(negedge clk);
    in_word  = 32'h5A5A_5A5A;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 ready low in commit", {63'h0, in_ready}, 64'h0);
    check("R10 mask not yet written", bin_mask, 64'h0);
    @(negedge clk);
    check("R10 ready back high", {63'h0, in_ready}, 64'h1);
    check("R10 R9 mask written", bin_mask, 64'hA5A5_A5A5_5A5A_5A5A);

    // R7 known opcode with count 0
    send_word(32'h0000_0061);
    go_idle(2);
    check("R7 count zero err", {63'h0, pkt_err}, 64'h1);
    check("R7 count zero no change", bin_mask, 64'hA5A5_A5A5_5A5A_5A5A);
    send_word(32'h0000_0160);
    send_word(32'h0000_0001);
    go_idle(3);
    check("R7 aligned after count zero", bin_mask, 64'hA5A5_A5A5_0000_0001);
    check("R11 select untouched", bin_select, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule